// File: doc/BRIEF.md
# Associative Address Translation Cache

This block caches recent virtual-to-physical page translations next to a CPU address port. Each cycle a request brings a virtual address and an access type. The page-number part of the address is compared against every stored entry at once. A matching entry that permits the access yields a physical address. That address is the stored frame number with the request's offset bits appended unchanged. A matching entry that does not permit the access raises a protection fault and returns no address.

When no entry matches, the block reports a miss and presents the missing page number to an external page-table walker. The walker later writes the translation back through the refill port. Each refill lands in the slot named by a round-robin pointer. A flush strobe invalidates every slot in a single cycle. Outcomes are registered, so they appear one clock after the request.

Top module: `tlb_xlate`

## Requirements
- R1: A valid request whose page number matches a valid entry whose permission allows the access gives `rsp_hit` high exactly one cycle later, with `rsp_miss` and `rsp_fault` low.
- R2: On a hit, `rsp_paddr` equals the entry's frame number in the upper bits, joined to the request's low offset bits, which pass through unchanged.
- R3: A valid request that matches no valid entry gives `rsp_miss` high one cycle later, with `miss_vpn` equal to the request's page number and `rsp_paddr` zero.
- R4: Access type is encoded on `req_acc` as 0 = read, 1 = write, 2 = execute, and 3 is reserved. Entry permission bits are bit 0 = read, bit 1 = write, bit 2 = execute. A matching entry whose bit for the access is clear, or any reserved access, gives `rsp_fault` high and `rsp_paddr` zero.
- R5: At most one of `rsp_hit`, `rsp_miss` and `rsp_fault` is high in any cycle. All three are low in the cycle after a cycle with no request.
- R6: An accepted refill writes the slot at a round-robin pointer. The pointer starts at 0 after reset, advances by one per accepted refill, and wraps from ENTRIES-1 to 0. The ninth refill with 8 entries therefore replaces the first one.
- R7: `flush` invalidates every entry in one cycle. A refill presented in the same cycle as `flush` is dropped and does not advance the pointer.
- R8: If several valid entries match, the lowest-index entry supplies the frame number and the permissions.
- R9: A lookup in the same cycle as a refill or a flush sees the table contents from before that cycle's update.
- R10: After reset all entries are invalid and all outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Lookup request strobe |
| req_vaddr | input | VPN_W+OFS_W | Virtual address: page number above, offset below |
| req_acc | input | 2 | Access type (0 read, 1 write, 2 execute, 3 reserved) |
| flush | input | 1 | Invalidate all entries |
| refill_valid | input | 1 | Refill write strobe from the walker |
| refill_vpn | input | VPN_W | Page number of the refill |
| refill_pfn | input | PFN_W | Frame number of the refill |
| refill_perm | input | 3 | Permissions {execute, write, read} |
| rsp_hit | output | 1 | Translation succeeded (registered) |
| rsp_miss | output | 1 | No entry matched; walker request (registered) |
| rsp_fault | output | 1 | Permission violation (registered) |
| rsp_paddr | output | PFN_W+OFS_W | Physical address on hit, zero otherwise |
| miss_vpn | output | VPN_W | Page number to walk on a miss, zero otherwise |

## Verification
The bench builds the block with its defaults: 8 entries, 20-bit page and frame numbers and a 12-bit offset. With only eight slots, filling the table and wrapping the replacement pointer takes nine refills. Duplicate-match ordering comes from a refill that repeats a page number. The same-cycle cases, refill against lookup and flush against refill, can be set up directly. The full-width fields let offsets of all-ones and all-zeros be checked for unchanged pass-through.

// File: rtl/tlb_pkg.sv
// Shared definitions for the translation cache: access-type codes and
// the bit position of each permission inside an entry's permission field.
package tlb_pkg;
    typedef enum logic [1:0] {
        ACC_READ  = 2'd0,
        ACC_WRITE = 2'd1,
        ACC_EXEC  = 2'd2,
        ACC_RSVD  = 2'd3
    } acc_e;

    localparam int PERM_W     = 3;
    localparam int PERM_BIT_R = 0;
    localparam int PERM_BIT_W = 1;
    localparam int PERM_BIT_X = 2;
endpackage

// File: rtl/tlb_entry_array.sv
// Storage for all translation slots plus one comparator per slot.
// Assumes the caller resolves flush/refill priority; flush here clears
// every valid bit and overrides any write in the same cycle.
module tlb_entry_array #(
    parameter int ENTRIES = 8,
    parameter int VPN_W   = 20,
    parameter int PFN_W   = 20,
    parameter int PERM_W  = 3,
    localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             clear_all,
    input  logic                             wr_en,
    input  logic [IDX_W-1:0]                 wr_idx,
    input  logic [VPN_W-1:0]                 wr_vpn,
    input  logic [PFN_W-1:0]                 wr_pfn,
    input  logic [PERM_W-1:0]                wr_perm,
    input  logic [VPN_W-1:0]                 look_vpn,
    output logic [ENTRIES-1:0]               match_vec,
    output logic [ENTRIES-1:0][PFN_W-1:0]    slot_pfn,
    output logic [ENTRIES-1:0][PERM_W-1:0]   slot_perm
);
    for (genvar g = 0; g < ENTRIES; g++) begin : g_slot
        logic             vld_q;
        logic [VPN_W-1:0] vpn_q;
        logic [PFN_W-1:0] pfn_q;
        logic [PERM_W-1:0] perm_q;
        logic             sel;

        assign sel = wr_en && (wr_idx == IDX_W'(g));

        // Slot state: reset/flush invalidate, selected refill loads.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                vld_q  <= 1'b0;
                vpn_q  <= '0;
                pfn_q  <= '0;
                perm_q <= '0;
            end else if (clear_all) begin
                vld_q <= 1'b0;
            end else if (sel) begin
                vld_q  <= 1'b1;
                vpn_q  <= wr_vpn;
                pfn_q  <= wr_pfn;
                perm_q <= wr_perm;
            end
        end

        // Parallel compare of this slot against the lookup page number.
        always_comb match_vec[g] = vld_q && (vpn_q == look_vpn);

        assign slot_pfn[g]  = pfn_q;
        assign slot_perm[g] = perm_q;
    end
endmodule

// File: rtl/tlb_first_match.sv
// Picks the lowest set bit of a match vector so duplicate matches
// resolve deterministically. Assumes nothing about how many bits are set.
module tlb_first_match #(
    parameter int ENTRIES = 8,
    localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
    input  logic [ENTRIES-1:0] match_vec,
    output logic               any,
    output logic [IDX_W-1:0]   idx
);
    // Scan from the top down so the lowest index is written last.
    always_comb begin
        any = 1'b0;
        idx = '0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (match_vec[i]) begin
                any = 1'b1;
                idx = IDX_W'(i);
            end
        end
    end
endmodule

// File: rtl/tlb_rr_ptr.sv
// Round-robin victim pointer. Advances once per accepted refill and
// wraps at ENTRIES-1; works for non-power-of-two depths.
module tlb_rr_ptr #(
    parameter int ENTRIES = 8,
    localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             step,
    output logic [IDX_W-1:0] ptr
);
    localparam logic [IDX_W-1:0] LAST = IDX_W'(ENTRIES - 1);

    // Pointer register: zero on reset, increment with wrap on step.
    always_ff @(posedge clk) begin
        if (!rst_n)
            ptr <= '0;
        else if (step)
            ptr <= (ptr == LAST) ? '0 : ptr + 1'b1;
    end
endmodule

// File: rtl/tlb_xlate.sv
// Fully associative translation cache top. Looks up every request in
// parallel, checks the permission for the access type, and registers a
// hit, miss or fault one cycle later. Assumes the walker presents refills
// on its own; flush takes priority over a same-cycle refill.
module tlb_xlate
    import tlb_pkg::*;
#(
    parameter int ENTRIES = 8,
    parameter int VPN_W   = 20,
    parameter int PFN_W   = 20,
    parameter int OFS_W   = 12,
    localparam int VA_W   = VPN_W + OFS_W,
    localparam int PA_W   = PFN_W + OFS_W,
    localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [VA_W-1:0]   req_vaddr,
    input  logic [1:0]        req_acc,
    input  logic              flush,
    input  logic              refill_valid,
    input  logic [VPN_W-1:0]  refill_vpn,
    input  logic [PFN_W-1:0]  refill_pfn,
    input  logic [2:0]        refill_perm,
    output logic              rsp_hit,
    output logic              rsp_miss,
    output logic              rsp_fault,
    output logic [PA_W-1:0]   rsp_paddr,
    output logic [VPN_W-1:0]  miss_vpn
);
    logic [VPN_W-1:0]                 req_vpn;
    logic [OFS_W-1:0]                 req_ofs;
    logic                             fill_ok;
    logic [IDX_W-1:0]                 victim;
    logic [ENTRIES-1:0]               match_vec;
    logic [ENTRIES-1:0][PFN_W-1:0]    slot_pfn;
    logic [ENTRIES-1:0][PERM_W-1:0]   slot_perm;
    logic                             any_match;
    logic [IDX_W-1:0]                 win_idx;
    logic [PERM_W-1:0]                win_perm;
    logic                             perm_ok;

    assign req_vpn = req_vaddr[VA_W-1:OFS_W];
    assign req_ofs = req_vaddr[OFS_W-1:0];
    assign fill_ok = refill_valid && !flush;

    tlb_rr_ptr #(.ENTRIES(ENTRIES)) u_ptr (
        .clk  (clk),
        .rst_n(rst_n),
        .step (fill_ok),
        .ptr  (victim)
    );

    tlb_entry_array #(
        .ENTRIES(ENTRIES), .VPN_W(VPN_W), .PFN_W(PFN_W), .PERM_W(PERM_W)
    ) u_arr (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear_all(flush),
        .wr_en    (fill_ok),
        .wr_idx   (victim),
        .wr_vpn   (refill_vpn),
        .wr_pfn   (refill_pfn),
        .wr_perm  (refill_perm),
        .look_vpn (req_vpn),
        .match_vec(match_vec),
        .slot_pfn (slot_pfn),
        .slot_perm(slot_perm)
    );

    tlb_first_match #(.ENTRIES(ENTRIES)) u_pick (
        .match_vec(match_vec),
        .any      (any_match),
        .idx      (win_idx)
    );

    assign win_perm = slot_perm[win_idx];

    // Permission check of the winning slot against the access type.
    always_comb begin
        unique case (acc_e'(req_acc))
            ACC_READ:  perm_ok = win_perm[PERM_BIT_R];
            ACC_WRITE: perm_ok = win_perm[PERM_BIT_W];
            ACC_EXEC:  perm_ok = win_perm[PERM_BIT_X];
            default:   perm_ok = 1'b0;
        endcase
    end

    // Registered outcome: exactly one flag per request, address on hit only.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_hit   <= 1'b0;
            rsp_miss  <= 1'b0;
            rsp_fault <= 1'b0;
            rsp_paddr <= '0;
            miss_vpn  <= '0;
        end else begin
            rsp_hit   <= req_valid && any_match && perm_ok;
            rsp_fault <= req_valid && any_match && !perm_ok;
            rsp_miss  <= req_valid && !any_match;
            rsp_paddr <= (req_valid && any_match && perm_ok)
                         ? {slot_pfn[win_idx], req_ofs} : '0;
            miss_vpn  <= (req_valid && !any_match) ? req_vpn : '0;
        end
    end
endmodule

// File: rtl/tlb_xlate_chk.sv
// Property checker for tlb_xlate, attached by bind. Observes ports only.
module tlb_xlate_chk #(
    parameter int VPN_W = 20,
    parameter int PFN_W = 20,
    parameter int OFS_W = 12,
    localparam int VA_W = VPN_W + OFS_W,
    localparam int PA_W = PFN_W + OFS_W
) (
    input logic             clk,
    input logic             rst_n,
    input logic             req_valid,
    input logic [VA_W-1:0]  req_vaddr,
    input logic             flush,
    input logic             rsp_hit,
    input logic             rsp_miss,
    input logic             rsp_fault,
    input logic [PA_W-1:0]  rsp_paddr,
    input logic [VPN_W-1:0] miss_vpn
);
    // R5: outcome flags never overlap
    p_excl_outcome_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({rsp_hit, rsp_miss, rsp_fault}));

    // R5: every request yields an outcome next cycle
    p_req_answered_r5: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> (rsp_hit || rsp_miss || rsp_fault));

    // R5: no request, no outcome
    p_idle_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !(rsp_hit || rsp_miss || rsp_fault));

    // R2: offset passes through on a hit
    p_ofs_pass_r2: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> (!rsp_hit || rsp_paddr[OFS_W-1:0] == $past(req_vaddr[OFS_W-1:0])));

    // R3: walker gets the page number that missed
    p_miss_vpn_r3: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> (!rsp_miss || miss_vpn == $past(req_vaddr[VA_W-1:OFS_W])));

    // R4: a fault returns no address
    p_fault_noaddr_r4: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_fault |-> (rsp_paddr == '0));

    // R7: first request after a flush cannot hit
    p_flush_empty_r7: assert property (@(posedge clk) disable iff (!rst_n)
        flush ##1 req_valid |=> !rsp_hit);
endmodule

bind tlb_xlate tlb_xlate_chk #(
    .VPN_W(VPN_W), .PFN_W(PFN_W), .OFS_W(OFS_W)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .req_valid(req_valid),
    .req_vaddr(req_vaddr),
    .flush    (flush),
    .rsp_hit  (rsp_hit),
    .rsp_miss (rsp_miss),
    .rsp_fault(rsp_fault),
    .rsp_paddr(rsp_paddr),
    .miss_vpn (miss_vpn)
);

// File: tb/sim_tlb_xlate.sv
module sim_tlb_xlate;
    localparam int ENTRIES = 8;
    localparam int VPN_W = 20;
    localparam int PFN_W = 20;
    localparam int OFS_W = 12;
    localparam int VA_W = VPN_W + OFS_W;
    localparam int PA_W = PFN_W + OFS_W;
    localparam int K_HIT = 0, K_MISS = 1, K_FAULT = 2;

    // Vector: vpn, offset, access, expected kind, expected paddr
    localparam int VW = 20 + 12 + 2 + 2 + 32;
    localparam logic [VW-1:0] VEC [10] = '{
        {20'h01001, 12'h123, 2'd0, 2'd0, 32'h0A003123},
        {20'h01001, 12'h123, 2'd1, 2'd2, 32'h00000000},
        {20'h01002, 12'hFFF, 2'd1, 2'd0, 32'h0A006FFF},
        {20'h01004, 12'h000, 2'd2, 2'd0, 32'h0A00C000},
        {20'h01004, 12'h000, 2'd0, 2'd2, 32'h00000000},
        {20'h01007, 12'hABC, 2'd2, 2'd0, 32'h0A015ABC},
        {20'h01007, 12'hABC, 2'd3, 2'd2, 32'h00000000},
        {20'h01000, 12'h555, 2'd0, 2'd2, 32'h00000000},
        {20'h02000, 12'h010, 2'd0, 2'd1, 32'h00000000},
        {20'h01006, 12'h001, 2'd1, 2'd0, 32'h0A012001}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 1'b0;
    logic [VA_W-1:0] req_vaddr = '0;
    logic [1:0] req_acc = '0;
    logic flush = 1'b0;
    logic refill_valid = 1'b0;
    logic [VPN_W-1:0] refill_vpn = '0;
    logic [PFN_W-1:0] refill_pfn = '0;
    logic [2:0] refill_perm = '0;
    logic rsp_hit, rsp_miss, rsp_fault;
    logic [PA_W-1:0] rsp_paddr;
    logic [VPN_W-1:0] miss_vpn;

    int n_run = 0;
    int n_fail = 0;

    always #5 clk = ~clk;

    tlb_xlate #(.ENTRIES(ENTRIES), .VPN_W(VPN_W), .PFN_W(PFN_W), .OFS_W(OFS_W)) u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_vaddr(req_vaddr),
        .req_acc(req_acc), .flush(flush), .refill_valid(refill_valid),
        .refill_vpn(refill_vpn), .refill_pfn(refill_pfn), .refill_perm(refill_perm),
        .rsp_hit(rsp_hit), .rsp_miss(rsp_miss), .rsp_fault(rsp_fault),
        .rsp_paddr(rsp_paddr), .miss_vpn(miss_vpn)
    );

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // Outcome encoded as {hit, miss, fault}
    function automatic logic [2:0] kind_bits(input int k);
        return (k == K_HIT) ? 3'b100 : (k == K_MISS) ? 3'b010 : 3'b001;
    endfunction

    // Starts at a negedge; ends at the next negedge with outputs sampled.
    task automatic lookup_check(input string tag, input logic [19:0] vpn,
                                input logic [11:0] ofs, input logic [1:0] acc,
                                input int kind, input logic [31:0] pa);
        req_valid = 1'b1;
        req_vaddr = {vpn, ofs};
        req_acc = acc;
        @(negedge clk);
        req_valid = 1'b0;
        check({tag, " outcome"}, 64'({rsp_hit, rsp_miss, rsp_fault}), 64'(kind_bits(kind)));
        check({tag, " paddr"}, 64'(rsp_paddr), 64'(pa));
        if (kind == K_MISS)
            check({tag, " miss_vpn"}, 64'(miss_vpn), 64'(vpn));
    endtask

    task automatic refill(input logic [19:0] vpn, input logic [19:0] pfn, input logic [2:0] perm);
        refill_valid = 1'b1;
        refill_vpn = vpn;
        refill_pfn = pfn;
        refill_perm = perm;
        @(negedge clk);
        refill_valid = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R10: outputs low under reset
        check("R10 reset outputs", 64'({rsp_hit, rsp_miss, rsp_fault, rsp_paddr}), 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        // R10: empty table after reset
        lookup_check("R10 empty after reset", 20'h01000, 12'h0, 2'd0, K_MISS, 32'h0);

        // Fill all slots: vpn 0x01000+i, pfn 0x0A000+3i, perm = i
        for (int i = 0; i < ENTRIES; i++)
            refill(20'h01000 + 20'(i), 20'h0A000 + 20'(3 * i), 3'(i));

        // R1 R2 R3 R4: vector table walk
        for (int v = 0; v < 10; v++) begin
            logic [VW-1:0] e;
            e = VEC[v];
            lookup_check($sformatf("R1/R2/R3/R4 vec%0d", v), e[67:48], e[47:36], e[35:34],
                         int'(e[33:32]), e[31:0]);
        end

        // R5: idle cycle gives no outcome
        @(negedge clk);
        check("R5 idle quiet", 64'({rsp_hit, rsp_miss, rsp_fault}), 64'd0);

        // R6: ninth refill wraps onto slot 0
        refill(20'h03000, 20'h0BBBB, 3'b111);
        lookup_check("R6 slot0 replaced", 20'h01000, 12'h0, 2'd0, K_MISS, 32'h0);
        lookup_check("R6 new entry hits", 20'h03000, 12'h042, 2'd0, K_HIT, 32'h0BBBB042);
        lookup_check("R6 slot1 kept", 20'h01001, 12'h7, 2'd0, K_HIT, 32'h0A003007);

        // R8: duplicate page in slot 1; lowest slot (0) wins
        refill(20'h03000, 20'h0CCCC, 3'b111);
        lookup_check("R8 lowest index wins", 20'h03000, 12'h111, 2'd1, K_HIT, 32'h0BBBB111);

        // R9: lookup in same cycle as refill sees old table
        refill_valid = 1'b1;
        refill_vpn = 20'h04000;
        refill_pfn = 20'h0DDDD;
        refill_perm = 3'b001;
        lookup_check("R9 same-cycle refill miss", 20'h04000, 12'h3, 2'd0, K_MISS, 32'h0);
        refill_valid = 1'b0;
        lookup_check("R9 refill visible next", 20'h04000, 12'h3, 2'd0, K_HIT, 32'h0DDDD003);

        // R7: flush with same-cycle refill; lookup in flush cycle still old
        flush = 1'b1;
        refill_valid = 1'b1;
        refill_vpn = 20'h05000;
        refill_pfn = 20'h0EEEE;
        refill_perm = 3'b111;
        lookup_check("R9 same-cycle flush sees old", 20'h01007, 12'h0, 2'd2, K_HIT, 32'h0A015000);
        flush = 1'b0;
        refill_valid = 1'b0;
        lookup_check("R7 flushed entry misses", 20'h01007, 12'h0, 2'd2, K_MISS, 32'h0);
        lookup_check("R7 dropped refill misses", 20'h05000, 12'h0, 2'd0, K_MISS, 32'h0);

        // R7 R6: dropped refill did not move pointer (was 3); fill 5 to reach slot 0
        for (int i = 0; i < 5; i++)
            refill(20'h06000 + 20'(i), 20'h0F000 + 20'(i), 3'b001);
        refill(20'h07000, 20'h01234, 3'b001);
        refill(20'h07001, 20'h05678, 3'b001);
        refill(20'h07002, 20'h09ABC, 3'b001);
        refill(20'h07003, 20'h0DEF0, 3'b001);
        // slot order now: 3..7 = 06000..06004, 0..2 = 07000..07002, 07003 -> slot 3
        lookup_check("R6 R7 pointer kept after drop", 20'h06000, 12'h0, 2'd0, K_MISS, 32'h0);
        lookup_check("R6 wrapped write", 20'h07003, 12'hFED, 2'd0, K_HIT, 32'h0DEF0FED);

        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule